// File: doc/BRIEF.md
# Inter-Column Load Balancer

This block balances the cache demand of sixteen jobs spread over four columns of four cores each. On a start pulse it captures one weight per job, which reflects how much cache that job needs, and a tolerance, and it places job j in column j/4. It then runs an iterative loop. In each cycle it sums the weights of every column and compares each column with the system-wide level. When a column is outside the tolerance, the loop exchanges the heaviest job of the most loaded column with the lightest job of the least loaded column. The loop ends when every column is inside the tolerance, or when it reaches an iteration cap, which it reports with a separate flag.

Every column holds the same number of jobs. For that reason the block compares scaled column sums and never divides: a column is within tolerance when |COLS*S_c - T| <= thr*COLS*JPC. Here S_c is the column sum, T is the total, and the right-hand side is the tolerance expressed in units of average weight. The result is a map from job to column, which a scheduler outside the block can use to migrate jobs.

Top module: `lb_swapper`

## Requirements
- R1: After reset, done_o and no_conv_o are 0 and the map is the identity placement: the field job_col_o[2j+1:2j] of job j reads j/4.
- R2: A start_i pulse seen while no run is active does three things. It captures weight_i (job j at bits [8j+7:8j]) and thresh_i. It restores the identity placement, with job j in position j%4 of column j/4. It brings done_o low in the following cycle.
- R3: A column is within tolerance when |4*S_c - T| <= 16*thr. When every column is within tolerance, the run ends with no further exchange.
- R4: When any column is out of tolerance, the heaviest job of the column with the largest sum trades places with the lightest job of the column with the smallest sum. Each job takes the other's position.
- R5: Ties for the largest or smallest column go to the lowest column index. Ties for the heaviest or lightest job go to the lowest position within the column.
- R6: Each cycle of a run performs at most one exchange. After a run that makes N exchanges, done_o first reads 1 in the (N+1)th cycle after the cycle in which start_i was sampled.
- R7: A run that has made 16 exchanges and is still out of tolerance ends with done_o and no_conv_o both 1. Otherwise no_conv_o ends at 0.
- R8: After a run, done_o, no_conv_o and the map hold until the next accepted start.
- R9: While a run is active, start_i has no effect. Changes on weight_i or thresh_i after the accepted start also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a balancing run (ignored while running) |
| weight_i | input | 128 | Cache-demand weight of each job, 8 bits per job |
| thresh_i | input | 8 | Tolerance in units of average job weight |
| job_col_o | output | 32 | Column of each job, 2 bits per job |
| done_o | output | 1 | Run finished; result valid |
| no_conv_o | output | 1 | Run stopped at the iteration cap without balance |

## Verification
The start pulse is sampled at one rising edge. From the next cycle on, each cycle evaluates the columns once and either exchanges a pair or ends the run. The bench therefore drives start_i at a falling edge and samples at falling edges. It checks that done_o is low half a cycle after the sampling edge. It counts the cycles until done_o rises and compares that count with the number of exchanges its own reference model predicts, plus one. It also checks that the map and both flags stay unchanged for several cycles after completion, and that a start pulse and a change of weights injected mid-run leave the final count, map and flag unchanged.

// File: rtl/lb_pkg.sv
// Shared types of the inter-column load balancer.
// Assumes nothing beyond the standard: plain enum for the run controller.
package lb_pkg;

    typedef enum logic [1:0] {
        LB_IDLE = 2'd0,
        LB_RUN  = 2'd1,
        LB_DONE = 2'd2
    } lb_state_e;

endpackage

// File: rtl/lb_job_pick.sv
// Picks, within one column, the position of the heaviest (FIND_MAX=1) or
// lightest (FIND_MAX=0) job weight. Ties resolve to the lowest position.
// Assumes weights are unsigned and packed position 0 in the low bits.
module lb_job_pick #(
    parameter int W        = 8,
    parameter int JPC      = 4,
    parameter bit FIND_MAX = 1'b1,
    parameter int KW       = (JPC > 1) ? $clog2(JPC) : 1
) (
    input  logic [JPC*W-1:0] w_i,
    output logic [KW-1:0]    idx_o
);

    if (FIND_MAX) begin : g_max
        // Scan for the first strictly largest weight.
        always_comb begin
            logic [W-1:0] best;
            best  = w_i[0 +: W];
            idx_o = '0;
            for (int k = 1; k < JPC; k++) begin
                if (w_i[k*W +: W] > best) begin
                    best  = w_i[k*W +: W];
                    idx_o = KW'(k);
                end
            end
        end
    end else begin : g_min
        // Scan for the first strictly smallest weight.
        always_comb begin
            logic [W-1:0] best;
            best  = w_i[0 +: W];
            idx_o = '0;
            for (int k = 1; k < JPC; k++) begin
                if (w_i[k*W +: W] < best) begin
                    best  = w_i[k*W +: W];
                    idx_o = KW'(k);
                end
            end
        end
    end

endmodule

// File: rtl/lb_col_eval.sv
// Sums the weights per column, tests each column against the tolerance
// using scaled sums (no division), and names the most and least loaded
// columns (lowest index on ties).
// Assumes every column holds exactly JPC jobs, slot s in column s/JPC.
module lb_col_eval #(
    parameter int W    = 8,
    parameter int COLS = 4,
    parameter int JPC  = 4,
    parameter int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS*JPC*W-1:0] slot_w_i,
    input  logic [W-1:0]          thr_i,
    output logic                  all_ok_o,
    output logic [CW-1:0]         hi_col_o,
    output logic [CW-1:0]         lo_col_o
);

    localparam int N  = COLS * JPC;
    localparam int SW = W + $clog2(JPC) + 1;
    localparam int TW = W + $clog2(N) + 1;
    localparam int DW = TW + $clog2(N) + 2;

    logic [COLS*SW-1:0] sums;
    logic [TW-1:0]      total;
    logic [DW-1:0]      tol;
    logic [COLS-1:0]    out_of_band;

    assign tol = DW'(thr_i) * DW'(N);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [SW-1:0] acc;
        logic [DW-1:0] scaled;
        logic [DW-1:0] dev;

        // Add the weights held in this column.
        always_comb begin
            acc = '0;
            for (int k = 0; k < JPC; k++) begin
                acc = acc + SW'(slot_w_i[(c*JPC+k)*W +: W]);
            end
        end

        assign sums[c*SW +: SW] = acc;
        assign scaled = DW'(acc) * DW'(COLS);

        // Absolute distance of the scaled column sum from the total.
        always_comb begin
            if (scaled >= DW'(total)) dev = scaled - DW'(total);
            else                      dev = DW'(total) - scaled;
        end

        assign out_of_band[c] = (dev > tol);
    end

    // System-wide total of all column sums.
    always_comb begin
        total = '0;
        for (int c = 0; c < COLS; c++) begin
            total = total + TW'(sums[c*SW +: SW]);
        end
    end

    assign all_ok_o = ~|out_of_band;

    // Locate the most and least loaded columns, first index wins ties.
    always_comb begin
        logic [SW-1:0] hv;
        logic [SW-1:0] lv;
        hv       = sums[0 +: SW];
        lv       = sums[0 +: SW];
        hi_col_o = '0;
        lo_col_o = '0;
        for (int c = 1; c < COLS; c++) begin
            if (sums[c*SW +: SW] > hv) begin
                hv       = sums[c*SW +: SW];
                hi_col_o = CW'(c);
            end
            if (sums[c*SW +: SW] < lv) begin
                lv       = sums[c*SW +: SW];
                lo_col_o = CW'(c);
            end
        end
    end

endmodule

// File: rtl/lb_slot_map.sv
// Holds which job sits in each slot, restores the identity placement on
// load, exchanges two slots on swap, and derives the job-to-column map.
// Assumes idx_a_i and idx_b_i are distinct valid slots when swap_i is high.
module lb_slot_map #(
    parameter int COLS = 4,
    parameter int JPC  = 4,
    parameter int JW   = $clog2(COLS*JPC),
    parameter int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  swap_i,
    input  logic [JW-1:0]         idx_a_i,
    input  logic [JW-1:0]         idx_b_i,
    output logic [COLS*JPC*JW-1:0] slot_o,
    output logic [COLS*JPC*CW-1:0] map_o
);

    localparam int N = COLS * JPC;

    logic [JW-1:0] slot_q [N];

    // Slot register update: identity on reset/load, pairwise exchange on swap.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            for (int s = 0; s < N; s++) slot_q[s] <= JW'(s);
        end else if (swap_i) begin
            for (int s = 0; s < N; s++) begin
                if (JW'(s) == idx_a_i)      slot_q[s] <= slot_q[idx_b_i];
                else if (JW'(s) == idx_b_i) slot_q[s] <= slot_q[idx_a_i];
            end
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_out
        assign slot_o[s*JW +: JW] = slot_q[s];
    end

    // Invert slot contents into a per-job column number.
    always_comb begin
        map_o = '0;
        for (int s = 0; s < N; s++) begin
            map_o[int'(slot_q[s])*CW +: CW] = CW'(s / JPC);
        end
    end

endmodule

// File: rtl/lb_ctrl.sv
// Run controller: one evaluation per cycle while running, ends on balance
// or after MAX_ITER exchanges, then holds the result until the next load.
// Assumes load_i is only raised by the top while no run is active.
module lb_ctrl #(
    parameter int MAX_ITER = 16,
    parameter int IW       = $clog2(MAX_ITER + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic all_ok_i,
    output logic run_o,
    output logic swap_o,
    output logic done_o,
    output logic no_conv_o
);

    import lb_pkg::*;

    lb_state_e     state_q;
    logic [IW-1:0] iter_q;
    logic          cap_hit;

    assign cap_hit = (iter_q == IW'(MAX_ITER));
    assign run_o   = (state_q == LB_RUN);
    assign done_o  = (state_q == LB_DONE);
    assign swap_o  = run_o && !all_ok_i && !cap_hit;

    // State, iteration count and cap flag sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LB_IDLE;
            iter_q    <= '0;
            no_conv_o <= 1'b0;
        end else if (load_i) begin
            state_q   <= LB_RUN;
            iter_q    <= '0;
            no_conv_o <= 1'b0;
        end else if (run_o) begin
            if (all_ok_i) begin
                state_q <= LB_DONE;
            end else if (cap_hit) begin
                state_q   <= LB_DONE;
                no_conv_o <= 1'b1;
            end else begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lb_swapper.sv
// Top of the inter-column load balancer. Captures weights and tolerance on
// an accepted start, then exchanges the heaviest job of the most loaded
// column with the lightest job of the least loaded column once per cycle
// until all columns are in tolerance or the iteration cap is reached.
// Assumes weight_i packs job j at bits [W*j+W-1:W*j].
module lb_swapper #(
    parameter int W        = 8,
    parameter int COLS     = 4,
    parameter int JPC      = 4,
    parameter int MAX_ITER = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [COLS*JPC*W-1:0]          weight_i,
    input  logic [W-1:0]                   thresh_i,
    output logic [COLS*JPC*((COLS > 1) ? $clog2(COLS) : 1)-1:0] job_col_o,
    output logic                           done_o,
    output logic                           no_conv_o
);

    localparam int N  = COLS * JPC;
    localparam int JW = $clog2(N);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int KW = (JPC > 1) ? $clog2(JPC) : 1;

    logic [N*W-1:0]  w_q;
    logic [W-1:0]    thr_q;
    logic [N*W-1:0]  slot_w;
    logic [N*JW-1:0] slot_flat;
    logic            run_w;
    logic            load_w;
    logic            swap_w;
    logic            all_ok_w;
    logic [CW-1:0]   hi_col;
    logic [CW-1:0]   lo_col;
    logic [KW-1:0]   heavy_pos;
    logic [KW-1:0]   light_pos;
    logic [JW-1:0]   idx_a;
    logic [JW-1:0]   idx_b;

    assign load_w = start_i && !run_w;

    // Capture the job weights and tolerance for the run being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q   <= '0;
            thr_q <= '0;
        end else if (load_w) begin
            w_q   <= weight_i;
            thr_q <= thresh_i;
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_slot_w
        assign slot_w[s*W +: W] = w_q[int'(slot_flat[s*JW +: JW])*W +: W];
    end

    lb_col_eval #(.W(W), .COLS(COLS), .JPC(JPC), .CW(CW)) u_eval (
        .slot_w_i (slot_w),
        .thr_i    (thr_q),
        .all_ok_o (all_ok_w),
        .hi_col_o (hi_col),
        .lo_col_o (lo_col)
    );

    lb_job_pick #(.W(W), .JPC(JPC), .FIND_MAX(1'b1), .KW(KW)) u_heavy (
        .w_i   (slot_w[int'(hi_col)*JPC*W +: JPC*W]),
        .idx_o (heavy_pos)
    );

    lb_job_pick #(.W(W), .JPC(JPC), .FIND_MAX(1'b0), .KW(KW)) u_light (
        .w_i   (slot_w[int'(lo_col)*JPC*W +: JPC*W]),
        .idx_o (light_pos)
    );

    assign idx_a = JW'(int'(hi_col) * JPC + int'(heavy_pos));
    assign idx_b = JW'(int'(lo_col) * JPC + int'(light_pos));

    lb_slot_map #(.COLS(COLS), .JPC(JPC), .JW(JW), .CW(CW)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .swap_i  (swap_w),
        .idx_a_i (idx_a),
        .idx_b_i (idx_b),
        .slot_o  (slot_flat),
        .map_o   (job_col_o)
    );

    lb_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .all_ok_i  (all_ok_w),
        .run_o     (run_w),
        .swap_o    (swap_w),
        .done_o    (done_o),
        .no_conv_o (no_conv_o)
    );

endmodule

// File: rtl/lb_swapper_chk.sv
// Property checker for lb_swapper, attached by bind below.
// Assumes the run indicator of the top is visible as run_w.
module lb_swapper_chk #(
    parameter int COLS = 4,
    parameter int JPC  = 4,
    parameter int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   run_w,
    input logic                   done_o,
    input logic                   no_conv_o,
    input logic [COLS*JPC*CW-1:0] job_col_o
);

    localparam int N = COLS * JPC;

    logic [N*CW-1:0] prev_map;
    logic [N-1:0]    moved;

    // Remember last cycle's map to count relocated jobs.
    always_ff @(posedge clk) begin
        prev_map <= job_col_o;
    end

    for (genvar j = 0; j < N; j++) begin : g_mv
        assign moved[j] = (prev_map[j*CW +: CW] != job_col_o[j*CW +: CW]);
    end

    a_r7_flag_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        no_conv_o |-> done_o);

    a_r6_pair_moves: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> (($countones(moved) == 0) || ($countones(moved) == 2)));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(job_col_o) && $stable(no_conv_o)));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_w) |=> (run_w && !done_o && !no_conv_o));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && start_i) |=> (run_w || done_o));

endmodule

bind lb_swapper lb_swapper_chk #(.COLS(COLS), .JPC(JPC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .run_w     (run_w),
    .done_o    (done_o),
    .no_conv_o (no_conv_o),
    .job_col_o (job_col_o)
);

// File: tb/sim_lb_swapper.sv
// Directed bench for lb_swapper; one task per scenario, plus a reference
// model of the greedy balancing rule for randomized weight sets.
module sim_lb_swapper;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] weight_i = '0;
    logic [7:0]   thresh_i = '0;
    logic [31:0]  job_col_o;
    logic         done_o;
    logic         no_conv_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wts [16];
    int thr_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_swapper u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .weight_i  (weight_i),
        .thresh_i  (thresh_i),
        .job_col_o (job_col_o),
        .done_o    (done_o),
        .no_conv_o (no_conv_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ident_map();
        logic [31:0] m;
        for (int j = 0; j < 16; j++) m[j*2 +: 2] = 2'(j / 4);
        return m;
    endfunction

    task automatic apply();
        for (int j = 0; j < 16; j++) weight_i[j*8 +: 8] = 8'(wts[j]);
        thresh_i = 8'(thr_v);
    endtask

    // Greedy rule worked from the requirements.
    task automatic model(output logic [31:0] emap, output int swaps, output bit enc);
        int sl [16];
        for (int s = 0; s < 16; s++) sl[s] = s;
        swaps = 0;
        enc   = 0;
        while (1) begin
            int cs [4];
            int tot;
            bit bad;
            int hc;
            int lc;
            int hs;
            int ls;
            int t;
            tot = 0;
            bad = 0;
            for (int c = 0; c < 4; c++) begin
                cs[c] = 0;
                for (int k = 0; k < 4; k++) cs[c] += wts[sl[c*4+k]];
                tot += cs[c];
            end
            for (int c = 0; c < 4; c++) begin
                int d;
                d = 4*cs[c] - tot;
                if (d < 0) d = -d;
                if (d > 16*thr_v) bad = 1;
            end
            if (!bad) break;
            if (swaps == 16) begin enc = 1; break; end
            hc = 0; lc = 0;
            for (int c = 1; c < 4; c++) begin
                if (cs[c] > cs[hc]) hc = c;
                if (cs[c] < cs[lc]) lc = c;
            end
            hs = hc*4; ls = lc*4;
            for (int k = 1; k < 4; k++) begin
                if (wts[sl[hc*4+k]] > wts[sl[hs]]) hs = hc*4+k;
                if (wts[sl[lc*4+k]] < wts[sl[ls]]) ls = lc*4+k;
            end
            t = sl[hs]; sl[hs] = sl[ls]; sl[ls] = t;
            swaps++;
        end
        for (int s = 0; s < 16; s++) emap[sl[s]*2 +: 2] = 2'(s / 4);
    endtask

    // Pulse start at a falling edge; count cycles until done rises.
    task automatic run_job(output int cyc);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R2 done low after start", done_o, 0);
        cyc = 0;
        while (!done_o && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_vs_model(input string tag);
        logic [31:0] em;
        int sw;
        bit enc;
        int cyc;
        model(em, sw, enc);
        apply();
        run_job(cyc);
        chk({tag, " R6 latency"}, cyc, sw + 1);
        chk({tag, " R7 flag"}, no_conv_o, enc);
        chk({tag, " R4 map"}, job_col_o, em);
    endtask

    task automatic t_reset();
        chk("R1 done at reset", done_o, 0);
        chk("R1 flag at reset", no_conv_o, 0);
        chk("R1 map at reset", job_col_o, ident_map());
    endtask

    task automatic t_balanced();
        int cyc;
        for (int j = 0; j < 16; j++) wts[j] = 10;
        thr_v = 0;
        apply();
        run_job(cyc);
        chk("R3 balanced latency", cyc, 1);
        chk("R3 balanced map", job_col_o, ident_map());
        chk("R7 balanced flag", no_conv_o, 0);
    endtask

    task automatic t_one_swap();
        int cyc;
        for (int j = 0; j < 16; j++) wts[j] = 10;
        wts[0] = 12; wts[1] = 12; wts[14] = 8; wts[15] = 8;
        thr_v = 0;
        apply();
        run_job(cyc);
        chk("R6 one swap latency", cyc, 2);
        chk("R5 job0 moved to col3", job_col_o[1:0], 3);
        chk("R5 job14 moved to col0", job_col_o[29:28], 0);
        chk("R5 job1 stays col0", job_col_o[3:2], 0);
        chk("R5 job15 stays col3", job_col_o[31:30], 3);
        run_vs_model("one swap");
    endtask

    task automatic t_col_tie();
        int cyc;
        for (int j = 0; j < 16; j++) wts[j] = 10;
        wts[0] = 12; wts[1] = 12; wts[4] = 12; wts[5] = 12;
        wts[10] = 8; wts[11] = 8; wts[14] = 8; wts[15] = 8;
        thr_v = 0;
        apply();
        run_job(cyc);
        chk("R6 two swap latency", cyc, 3);
        chk("R5 job0 to col2", job_col_o[1:0], 2);
        chk("R5 job10 to col0", job_col_o[21:20], 0);
        chk("R5 job4 to col3", job_col_o[9:8], 3);
        chk("R5 job14 to col1", job_col_o[29:28], 1);
    endtask

    task automatic t_tolerance();
        int cyc;
        for (int j = 0; j < 16; j++) wts[j] = 10;
        wts[0] = 18; wts[15] = 2;
        thr_v = 2;
        apply();
        run_job(cyc);
        chk("R3 deviation equal to tolerance latency", cyc, 1);
        chk("R3 deviation equal to tolerance map", job_col_o, ident_map());
    endtask

    task automatic t_cap();
        int cyc;
        logic [31:0] m;
        for (int j = 0; j < 16; j++) wts[j] = 10;
        wts[0] = 18; wts[15] = 2;
        thr_v = 1;
        apply();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R2 done low after start", done_o, 0);
        cyc = 0;
        while (!done_o && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cyc == 4) begin
                weight_i = {16{8'd10}};
                thresh_i = 8'd9;
                start_i  = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        chk("R9 R7 cap latency", cyc, 17);
        chk("R7 cap flag", no_conv_o, 1);
        chk("R7 cap map after even swaps", job_col_o, ident_map());
        m = job_col_o;
        repeat (3) @(negedge clk);
        chk("R8 done held", done_o, 1);
        chk("R8 flag held", no_conv_o, 1);
        chk("R8 map held", job_col_o, m);
    endtask

    task automatic t_random();
        for (int r = 0; r < 8; r++) begin
            for (int j = 0; j < 16; j++) wts[j] = int'($urandom_range(0, 63));
            thr_v = int'($urandom_range(0, 3));
            run_vs_model("random");
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_balanced();
        t_one_swap();
        t_col_tie();
        t_tolerance();
        t_cap();
        t_random();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule